// File: doc/BRIEF.md
# Window Watchdog Timer with Activation Code

This block is a window watchdog for a large chip. It counts pulses of a separate counter-clock tick enable. Software must restart the count by writing an activation code, and the write must land inside an allowed window of the interval. There are two code schemes. In the fixed scheme software writes the constant 0xAC to a trigger register. In the variable scheme software reads a reference byte and writes 0xAC minus that byte to a second trigger register. After each valid variable trigger the reference byte moves to a new value.

An error event is raised when the count runs to the end of the interval, when a trigger arrives too early, when a code is wrong, or when a trigger uses the register of the scheme that is not selected. Each error event becomes either a one-cycle reset request or a sticky interrupt. An optional one-cycle early-warning pulse fires when the count reaches three quarters of the interval. Two static inputs switch the whole function on and select the code scheme. The register interface is one byte wide and has a combinational read path.

The control is a four-state machine. `ST_OFF` is the disabled state. `ST_CLOSED` counts while triggers are still forbidden. `ST_OPEN` counts while triggers are accepted. `ST_FAULT` lasts one cycle and issues the error event. The transitions are as follows:
- enable low takes any state to `ST_OFF`.
- `ST_OFF` and `ST_FAULT` go to a restart, which is `ST_OPEN` for window code 0 and `ST_CLOSED` otherwise.
- `ST_CLOSED` goes to `ST_OPEN` when the count reaches the window start.
- a valid trigger or a mode write in `ST_OPEN`, or a mode write in `ST_CLOSED`, goes to a restart.
- an early or bad trigger, or an overflow, goes to `ST_FAULT`.

Top module: `win_watchdog`

## Requirements
- R1: In fixed-code scheme (`code_var_sel`=0), a write of 0xAC to offset 0x0 while the window is open raises no error and clears the count to zero. The next overflow error then comes exactly one full interval of ticks later.
- R2: Offset 0x8 reads the reference byte, which is 0x5A after reset. In variable-code scheme (`code_var_sel`=1), a write of (0xAC − reference) mod 256 to offset 0x4 while the window is open is a valid trigger. After it the reference becomes {ref[6:0], ref[7]^ref[5]^ref[4]^ref[3]}. No other event changes the reference.
- R3: Offset 0xC is the mode register and resets to 0x00. Its fields are: bits 6:4 overflow select, bit 3 early-warning enable, bit 2 error kind, bits 1:0 window code. Bit 7 reads 0, and offsets 0x0 and 0x4 read 0. A mode write restarts the count from zero.
- R4: The interval is 2^(BASE_EXP + overflow select) ticks. With ticks on every cycle and no valid trigger, the error event appears N cycles after the clock edge that restarted the count.
- R5: Window code 0 accepts triggers at any count. Codes 1, 2 and 3 accept triggers only at counts of at least N−N/4, N−N/2 and N−3N/4 respectively. A trigger at a lower count is an error.
- R6: A code value other than the required one is an error. So is a write to the trigger register of the scheme that is not selected.
- R7: With error kind 0, an error drives `rst_req` high for exactly one cycle. With error kind 1, `err_irq` rises instead and stays high until reset, and `rst_req` stays low. In both cases the count restarts from zero one cycle after the error.
- R8: With bit 3 set, `pre_irq` pulses for one cycle once the count reaches 3N/4. With bit 3 clear, it never pulses.
- R9: While `wd_enable` is low, nothing counts, no error is raised and trigger writes are ignored (the reference is unchanged). After `wd_enable` rises, the count starts from zero.
- R10: The count advances only in cycles with `cnt_tick` high. Otherwise it holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt_tick | input | 1 | Counter-clock tick enable |
| wd_enable | input | 1 | Static watchdog enable |
| code_var_sel | input | 1 | 0 = fixed code scheme, 1 = variable code scheme |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rdata | output | 8 | Combinational read data |
| rst_req | output | 1 | One-cycle reset request on error |
| err_irq | output | 1 | Sticky error interrupt |
| pre_irq | output | 1 | One-cycle 75% early-warning pulse |

## Verification
The bench builds the block with BASE_EXP=3 instead of the default 9. Intervals then run from 8 to 1024 ticks, so overflow, the edges of every window and the early-warning point are all reached within tens of cycles. The bench can count the exact cycle of each event that way. The reference step and the activation code keep their default values, so the bench's own model of the reference sequence starts from 0x5A. The window boundaries are hit one count below and exactly at the start.

// File: rtl/wwd_pkg.sv
package wwd_pkg;

    localparam int SEL_W  = 3;
    localparam int DATA_W = 8;

    localparam logic [3:0] OFS_TRIG_FIX = 4'h0;
    localparam logic [3:0] OFS_TRIG_VAR = 4'h4;
    localparam logic [3:0] OFS_REF      = 4'h8;
    localparam logic [3:0] OFS_MODE     = 4'hC;

    typedef enum logic [1:0] {
        ST_OFF,
        ST_CLOSED,
        ST_OPEN,
        ST_FAULT
    } wwd_state_e;

    typedef struct packed {
        logic [SEL_W-1:0] ovf_sel;
        logic             pre_en;
        logic             irq_kind;
        logic [1:0]       win;
    } wwd_mode_t;

endpackage

// File: rtl/wwd_refgen.sv
module wwd_refgen #(
    parameter int          W    = 8,
    parameter logic [W-1:0] SEED = 8'h5A
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         adv,
    output logic [W-1:0] ref_val
);

    logic [W-1:0] ref_q;
    logic         fb;

    always_comb begin
        fb = ref_q[W-1] ^ ref_q[W-3] ^ ref_q[W-4] ^ ref_q[W-5];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ref_q <= SEED;
        end else if (adv) begin
            ref_q <= {ref_q[W-2:0], fb};
        end
    end

    assign ref_val = ref_q;

    a_r2_ref_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        ref_q != '0);

    a_r2_ref_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> $stable(ref_q));

endmodule

// File: rtl/wwd_regbank.sv
module wwd_regbank
    import wwd_pkg::*;
#(
    parameter int               ADDR_W   = 4,
    parameter logic [DATA_W-1:0] ACT_CODE = 8'hAC
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              var_sel,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              wr,
    input  logic [DATA_W-1:0] ref_val,
    output logic [DATA_W-1:0] rdata,
    output wwd_mode_t         mode_q,
    output wwd_mode_t         mode_nx,
    output logic              mode_wr,
    output logic              trig_hit,
    output logic              trig_ok,
    output logic              trig_var
);

    logic              hit_fix;
    logic              hit_var;
    logic [DATA_W-1:0] var_code;

    always_comb begin
        hit_fix  = (addr == ADDR_W'(OFS_TRIG_FIX));
        hit_var  = (addr == ADDR_W'(OFS_TRIG_VAR));
        var_code = ACT_CODE - ref_val;
        mode_wr  = wr && (addr == ADDR_W'(OFS_MODE));
        trig_hit = en && wr && (hit_fix || hit_var);
        trig_var = hit_var;
        trig_ok  = (hit_fix && !var_sel && (wdata == ACT_CODE)) ||
                   (hit_var &&  var_sel && (wdata == var_code));
        mode_nx  = mode_wr ? wwd_mode_t'(wdata[6:0]) : mode_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= '0;
        end else begin
            mode_q <= mode_nx;
        end
    end

    always_comb begin
        rdata = '0;
        if (addr == ADDR_W'(OFS_REF)) begin
            rdata = ref_val;
        end else if (addr == ADDR_W'(OFS_MODE)) begin
            rdata = {1'b0, mode_q};
        end
    end

    a_r3_mode_held: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_wr |=> $stable(mode_q));

endmodule

// File: rtl/wwd_timer_fsm.sv
module wwd_timer_fsm
    import wwd_pkg::*;
#(
    parameter int BASE_EXP = 9
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      en,
    input  logic      tick,
    input  logic      var_sel,
    input  wwd_mode_t mode_q,
    input  wwd_mode_t mode_nx,
    input  logic      mode_wr,
    input  logic      trig_hit,
    input  logic      trig_ok,
    input  logic      trig_var,
    output logic      ref_adv,
    output logic      rst_req,
    output logic      err_irq,
    output logic      pre_irq
);

    localparam int MAX_EXP = BASE_EXP + (1 << SEL_W) - 1;
    localparam int CNT_W   = MAX_EXP + 1;

    wwd_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [CNT_W-1:0] ivl, quarter, win_start, three_q, cnt_inc;
    wwd_state_e       restart_st;
    logic             fault_ev;
    logic             pre_hit;
    logic             rst_req_q, err_irq_q, pre_irq_q;

    // interval geometry from the live mode
    always_comb begin
        ivl     = CNT_W'(1) << (BASE_EXP + int'(mode_q.ovf_sel));
        quarter = ivl >> 2;
        three_q = ivl - quarter;
        cnt_inc = cnt_q + CNT_W'(1);
        unique case (mode_q.win)
            2'd0: win_start = '0;
            2'd1: win_start = ivl - quarter;
            2'd2: win_start = ivl - (quarter << 1);
            2'd3: win_start = quarter;
            default: win_start = '0;
        endcase
        restart_st = (mode_nx.win == 2'd0) ? ST_OPEN : ST_CLOSED;
    end

    // next-state and counter logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        ref_adv = 1'b0;
        pre_hit = 1'b0;
        if (!en) begin
            state_d = ST_OFF;
            cnt_d   = '0;
        end else begin
            unique case (state_q)
                ST_OFF, ST_FAULT: begin
                    state_d = restart_st;
                    cnt_d   = '0;
                end
                ST_CLOSED, ST_OPEN: begin
                    if (mode_wr) begin
                        state_d = restart_st;
                        cnt_d   = '0;
                    end else if (trig_hit) begin
                        cnt_d = '0;
                        if (state_q == ST_OPEN && trig_ok) begin
                            state_d = restart_st;
                            ref_adv = trig_var && var_sel;
                        end else begin
                            state_d = ST_FAULT;
                        end
                    end else if (tick) begin
                        if (cnt_q == ivl - CNT_W'(1)) begin
                            state_d = ST_FAULT;
                            cnt_d   = '0;
                        end else begin
                            cnt_d   = cnt_inc;
                            pre_hit = mode_q.pre_en && (cnt_inc == three_q);
                            if (state_q == ST_CLOSED && cnt_inc == win_start) begin
                                state_d = ST_OPEN;
                            end
                        end
                    end
                end
                default: begin
                    state_d = ST_OFF;
                    cnt_d   = '0;
                end
            endcase
        end
        fault_ev = (state_d == ST_FAULT) && (state_q != ST_FAULT);
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rst_req_q <= 1'b0;
            err_irq_q <= 1'b0;
            pre_irq_q <= 1'b0;
        end else begin
            rst_req_q <= fault_ev && !mode_q.irq_kind;
            err_irq_q <= err_irq_q || (fault_ev && mode_q.irq_kind);
            pre_irq_q <= pre_hit;
        end
    end

    assign rst_req = rst_req_q;
    assign err_irq = err_irq_q;
    assign pre_irq = pre_irq_q;

    a_r7_fault_single: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_FAULT |=> state_q != ST_FAULT);

    a_r7_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        err_irq_q |=> err_irq_q);

    a_r7_rst_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req_q |=> !rst_req_q);

    a_r5_early_trigger: assert property (@(posedge clk) disable iff (!rst_n)
        (en && state_q == ST_CLOSED && trig_hit) |=> state_q == ST_FAULT);

    a_r9_off_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (state_q == ST_OFF && cnt_q == '0));

    a_r4_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < ivl);

    a_r8_pre_single: assert property (@(posedge clk) disable iff (!rst_n)
        pre_irq_q |=> !pre_irq_q);

    a_r10_tick_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !tick && !trig_hit && !mode_wr &&
         (state_q == ST_CLOSED || state_q == ST_OPEN)) |=> $stable(cnt_q));

endmodule

// File: rtl/win_watchdog.sv
module win_watchdog
    import wwd_pkg::*;
#(
    parameter int                BASE_EXP = 9,
    parameter int                ADDR_W   = 4,
    parameter logic [DATA_W-1:0] ACT_CODE = 8'hAC,
    parameter logic [DATA_W-1:0] REF_SEED = 8'h5A
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cnt_tick,
    input  logic              wd_enable,
    input  logic              code_var_sel,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    input  logic              bus_wr,
    output logic [7:0]        bus_rdata,
    output logic              rst_req,
    output logic              err_irq,
    output logic              pre_irq
);

    logic [DATA_W-1:0] ref_val;
    wwd_mode_t         mode_q, mode_nx;
    logic              mode_wr, trig_hit, trig_ok, trig_var, ref_adv;

    wwd_regbank #(
        .ADDR_W   (ADDR_W),
        .ACT_CODE (ACT_CODE)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (wd_enable),
        .var_sel  (code_var_sel),
        .addr     (bus_addr),
        .wdata    (bus_wdata),
        .wr       (bus_wr),
        .ref_val  (ref_val),
        .rdata    (bus_rdata),
        .mode_q   (mode_q),
        .mode_nx  (mode_nx),
        .mode_wr  (mode_wr),
        .trig_hit (trig_hit),
        .trig_ok  (trig_ok),
        .trig_var (trig_var)
    );

    wwd_refgen #(
        .W    (DATA_W),
        .SEED (REF_SEED)
    ) u_ref (
        .clk     (clk),
        .rst_n   (rst_n),
        .adv     (ref_adv),
        .ref_val (ref_val)
    );

    wwd_timer_fsm #(
        .BASE_EXP (BASE_EXP)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (wd_enable),
        .tick     (cnt_tick),
        .var_sel  (code_var_sel),
        .mode_q   (mode_q),
        .mode_nx  (mode_nx),
        .mode_wr  (mode_wr),
        .trig_hit (trig_hit),
        .trig_ok  (trig_ok),
        .trig_var (trig_var),
        .ref_adv  (ref_adv),
        .rst_req  (rst_req),
        .err_irq  (err_irq),
        .pre_irq  (pre_irq)
    );

endmodule

// File: tb/test_win_watchdog.sv
`timescale 1ns/1ps
module test_win_watchdog;

    localparam int BASE_EXP = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cnt_tick = 1'b1;
    logic       wd_enable = 1'b1;
    logic       code_var_sel = 1'b0;
    logic [3:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_rdata;
    logic       rst_req, err_irq, pre_irq;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    win_watchdog #(.BASE_EXP(BASE_EXP)) i_win_watchdog (
        .clk          (clk),
        .rst_n        (rst_n),
        .cnt_tick     (cnt_tick),
        .wd_enable    (wd_enable),
        .code_var_sel (code_var_sel),
        .bus_addr     (bus_addr),
        .bus_wdata    (bus_wdata),
        .bus_wr       (bus_wr),
        .bus_rdata    (bus_rdata),
        .rst_req      (rst_req),
        .err_irq      (err_irq),
        .pre_irq      (pre_irq)
    );

    function automatic int ivl_of(input int sel);
        return 1 << (BASE_EXP + sel);
    endfunction

    function automatic logic [7:0] lfsr_step(input logic [7:0] x);
        return {x[6:0], x[7] ^ x[5] ^ x[4] ^ x[3]};
    endfunction

    function automatic logic [7:0] mode_byte(input int sel, input bit pre,
                                             input bit kind, input int win);
        return {1'b0, 3'(sel), pre, kind, 2'(win)};
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // all tasks start and end at a falling edge
    task automatic bus_write(input logic [3:0] a, input logic [7:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic bus_read(input logic [3:0] a, output logic [7:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // from a restart edge: quiet for N-1 falling edges, error on the Nth
    task automatic expect_overflow(input string tag, input int n);
        repeat (n - 1) @(negedge clk);
        check({tag, " quiet before end"}, rst_req, 0);
        @(negedge clk);
        check({tag, " error at end"}, rst_req, 1);
    endtask

    task automatic t_reset();
        logic [7:0] d;
        check("R7 rst_req after reset", rst_req, 0);
        check("R7 err_irq after reset", err_irq, 0);
        check("R8 pre_irq after reset", pre_irq, 0);
        bus_read(4'hC, d); check("R3 mode reset value", d, 8'h00);
        bus_read(4'h8, d); check("R2 reference seed", d, 8'h5A);
        bus_read(4'h0, d); check("R3 fixed trigger reads zero", d, 0);
    endtask

    task automatic t_mode_reg();
        logic [7:0] d;
        bus_write(4'hC, 8'hFF);
        bus_read(4'hC, d); check("R3 bit7 reads zero", d, 8'h7F);
        bus_write(4'hC, 8'h35);
        bus_read(4'hC, d); check("R3 mode readback", d, 8'h35);
        bus_read(4'h4, d); check("R3 var trigger reads zero", d, 0);
    endtask

    task automatic t_overflow();
        bus_write(4'hC, mode_byte(0, 0, 0, 0));
        expect_overflow("R4 sel0", ivl_of(0));
        bus_write(4'hC, mode_byte(2, 0, 0, 0));
        expect_overflow("R4 sel2", ivl_of(2));
    endtask

    task automatic t_fixed_trigger();
        code_var_sel = 1'b0;
        bus_write(4'hC, mode_byte(0, 0, 0, 0));
        repeat (3) @(negedge clk);
        bus_write(4'h0, 8'hAC);
        check("R1 valid fixed trigger no error", rst_req, 0);
        expect_overflow("R1 count cleared", ivl_of(0));
    endtask

    task automatic t_window();
        // code 1 at N=8 opens at count 6
        bus_write(4'hC, mode_byte(0, 0, 0, 1));
        repeat (5) @(negedge clk);
        bus_write(4'h0, 8'hAC);
        check("R5 code1 one below start faults", rst_req, 1);
        bus_write(4'hC, mode_byte(0, 0, 0, 1));
        repeat (6) @(negedge clk);
        bus_write(4'h0, 8'hAC);
        check("R5 code1 at start accepted", rst_req, 0);
        expect_overflow("R5 code1 restart", ivl_of(0));
        // code 3 opens at count 2
        bus_write(4'hC, mode_byte(0, 0, 0, 3));
        repeat (1) @(negedge clk);
        bus_write(4'h0, 8'hAC);
        check("R5 code3 early faults", rst_req, 1);
        bus_write(4'hC, mode_byte(0, 0, 0, 3));
        repeat (2) @(negedge clk);
        bus_write(4'h0, 8'hAC);
        check("R5 code3 at start accepted", rst_req, 0);
        // code 2 at N=16 opens at count 8
        bus_write(4'hC, mode_byte(1, 0, 0, 2));
        repeat (7) @(negedge clk);
        bus_write(4'h0, 8'hAC);
        check("R5 code2 early faults", rst_req, 1);
    endtask

    task automatic t_wrong_code();
        code_var_sel = 1'b0;
        bus_write(4'hC, mode_byte(0, 0, 0, 0));
        bus_write(4'h0, 8'hAB);
        check("R6 wrong fixed code", rst_req, 1);
        @(negedge clk);
        check("R7 reset request one cycle", rst_req, 0);
        repeat (ivl_of(0) - 1) @(negedge clk);
        check("R7 restart quiet", rst_req, 0);
        @(negedge clk);
        check("R7 restart then overflow", rst_req, 1);
        bus_write(4'hC, mode_byte(0, 0, 0, 0));
        bus_write(4'h4, 8'hAC);
        check("R6 inactive var register", rst_req, 1);
    endtask

    task automatic t_variable();
        logic [7:0] r, r2;
        code_var_sel = 1'b1;
        bus_write(4'hC, mode_byte(0, 0, 0, 0));
        bus_read(4'h8, r);
        check("R2 reference before trigger", r, 8'h5A);
        bus_write(4'h4, 8'hAC - r);
        check("R2 valid var trigger no error", rst_req, 0);
        bus_read(4'h8, r2);
        check("R2 reference advanced", r2, lfsr_step(8'h5A));
        bus_write(4'h4, 8'hAC - r2);
        check("R2 second var trigger", rst_req, 0);
        bus_read(4'h8, r);
        check("R2 reference second step", r, lfsr_step(lfsr_step(8'h5A)));
        bus_write(4'h4, 8'hAC - r + 8'd1);
        check("R6 wrong var code", rst_req, 1);
        bus_read(4'h8, r2);
        check("R2 reference held on bad code", r2, r);
        bus_write(4'hC, mode_byte(0, 0, 0, 0));
        bus_write(4'h0, 8'hAC);
        check("R6 inactive fixed register", rst_req, 1);
        code_var_sel = 1'b0;
    endtask

    task automatic t_pre();
        bus_write(4'hC, mode_byte(0, 1, 0, 0));
        repeat (5) @(negedge clk);
        check("R8 no early pulse yet", pre_irq, 0);
        @(negedge clk);
        check("R8 pulse at three quarters", pre_irq, 1);
        @(negedge clk);
        check("R8 pulse one cycle", pre_irq, 0);
        bus_write(4'hC, mode_byte(0, 0, 0, 0));
        repeat (6) @(negedge clk);
        check("R8 disabled no pulse", pre_irq, 0);
    endtask

    task automatic t_disable();
        logic [7:0] r;
        int hits = 0;
        wd_enable = 1'b0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (rst_req) hits++;
        end
        check("R9 no errors while off", hits, 0);
        bus_write(4'h0, 8'h11);
        check("R9 bad trigger ignored", rst_req, 0);
        code_var_sel = 1'b1;
        bus_read(4'h8, r);
        bus_write(4'h4, 8'hAC - r);
        bus_read(4'h8, bus_wdata);
        check("R9 reference unchanged", bus_wdata, r);
        code_var_sel = 1'b0;
        wd_enable = 1'b1;
        repeat (ivl_of(0)) @(negedge clk);
        check("R9 restart quiet", rst_req, 0);
        @(negedge clk);
        check("R9 restart from zero", rst_req, 1);
    endtask

    task automatic t_tick();
        int hits = 0;
        cnt_tick = 1'b0;
        bus_write(4'hC, mode_byte(0, 0, 0, 0));
        for (int i = 0; i < 50; i++) begin
            @(negedge clk);
            if (rst_req) hits++;
        end
        check("R10 no count without tick", hits, 0);
        cnt_tick = 1'b1;
        expect_overflow("R10 count held", ivl_of(0));
    endtask

    task automatic t_irq_kind();
        bus_write(4'hC, mode_byte(0, 0, 1, 0));
        bus_write(4'h0, 8'h00);
        check("R7 irq kind no reset request", rst_req, 0);
        check("R7 irq raised", err_irq, 1);
        repeat (3 * ivl_of(0)) @(negedge clk);
        check("R7 irq sticky", err_irq, 1);
        check("R7 irq kind overflow no reset", rst_req, 0);
        do_reset();
        check("R7 irq cleared by reset", err_irq, 0);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        do_reset();
        t_reset();
        t_mode_reg();
        t_overflow();
        t_fixed_trigger();
        t_window();
        t_wrong_code();
        t_variable();
        t_pre();
        t_disable();
        t_tick();
        t_irq_kind();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule